// File: doc/BRIEF.md
# Program Busy Status Reporter

This block sits in the read path of a self-timed nonvolatile memory. When no internal program cycle is running, a read strobe returns the array data for the addressed location. While a program cycle is running, the array cannot be read. Every read then returns a status word that lets a host detect when the cycle has finished, using either of two polling methods.

In the complement method, a read of the address that was loaded last returns the inverse of that byte's top bit. In the toggle method, the bit just below the top bit changes value on every read strobe, whatever address is read. The host compares two reads in a row to see whether that bit is still changing.

The busy flag comes from the program sequencer. It covers every write-cycle interval, including the dummy interval started by a write that protection has rejected. The block treats all of these the same way. Reads are synchronous: a strobe is sampled on a clock edge, and the result appears on the output register after that edge.

Top module: `bsr_top`

## Requirements
- R1: After reset the read data output is all zeros and the toggle state is 0.
- R2: A read strobe sampled while busy is low loads the array data into the read output on that edge. The output is valid from the following cycle.
- R3: A read strobe sampled while busy is high, whose address equals the last loaded address, returns the inverse of bit 7 of the last loaded byte on bit 7.
- R4: A busy read at any other address returns 0 on bit 7.
- R5: Successive busy reads return alternating values on bit 6, whatever address is read. The first busy read after a program cycle starts returns 0.
- R6: During busy reads, bits 5 down to 0 are returned as 0.
- R7: The first read sampled with busy low after a program cycle returns the true array data on all eight bits, bits 7 and 6 included.
- R8: The toggle state is cleared to 0 when a program cycle starts, even if the previous cycle ended with it at 1.
- R9: While no read strobe is present, the read output and the toggle state keep their values.
- R10: A read strobe sampled on the same edge where busy rises returns a status word with bit 6 equal to 0. The next busy read returns 1 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program or dummy write cycle is running |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Address of the current read |
| last_addr_i | input | ADDR_W | Address of the last byte loaded before the cycle |
| last_data_i | input | DATA_W | Last byte loaded before the cycle |
| array_data_i | input | DATA_W | Array read data for rd_addr_i |
| rdata_o | output | DATA_W | Registered read data |

## Verification
Two events can land on the same clock edge: a read strobe, and a change of the busy flag. If busy rises with a read on that edge, the toggle clear and the toggle flip both happen at once. If busy falls with a read on that edge, the read must switch to array data without a cycle of delay. The bench drives a read strobe on exactly those edges. It then judges the returned word against a toggle count it keeps itself: on the rising edge, bit 6 must be 0 and the next busy read must show 1. On the falling edge, the returned word must equal the array value, with no inverted bit 7 and no toggle bit.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // status word: poll bit on MSB, toggle bit below it, rest zero
  function automatic logic [7:0] status_word(input logic poll_bit, input logic tog_bit);
    status_word = {poll_bit, tog_bit, 6'b0};
  endfunction
endpackage

// File: rtl/bsr_toggle.sv
module bsr_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic busy_q, tog_q, start;

  assign start = busy_i & ~busy_q;
  // value returned by a read on this edge
  assign tog_o = start ? 1'b0 : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (rd_i && busy_i) tog_q <= ~tog_o;
      else if (start)     tog_q <= 1'b0;
    end
  end

  // R5
  flip_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && busy_q) |=> (tog_q != $past(tog_q)));
  // R9
  hold_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !(busy_i && !busy_q)) |=> $stable(tog_q));
  // R8
  clear_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !busy_q && !rd_i) |=> (tog_q == 1'b0));
endmodule

// File: rtl/bsr_status_mux.sv
module bsr_status_mux #(
  parameter int ADDR_W = 16
) (
  input  logic              busy_i,
  input  logic              tog_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [7:0]        last_data_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        word_o
);
  import bsr_pkg::*;
  logic hit;

  assign hit = (rd_addr_i == last_addr_i);

  always_comb begin
    if (busy_i) word_o = status_word(hit & ~last_data_i[7], tog_i);
    else        word_o = array_data_i;
  end
endmodule

// File: rtl/bsr_top.sv
module bsr_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic       tog;
  logic [7:0] word;

  bsr_toggle u_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .rd_i  (rd_i),
    .tog_o (tog)
  );

  bsr_status_mux #(.ADDR_W(ADDR_W)) u_mux (
    .busy_i      (busy_i),
    .tog_i       (tog),
    .rd_addr_i   (rd_addr_i),
    .last_addr_i (last_addr_i),
    .last_data_i (last_data_i[7:0]),
    .array_data_i(array_data_i[7:0]),
    .word_o      (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= DATA_W'(word);
  end

  // R2 R7
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> (rdata_o == $past(array_data_i)));
  // R6
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> (rdata_o[5:0] == 6'b0));
  // R4
  miss_poll_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && (rd_addr_i != last_addr_i)) |=> (rdata_o[7] == 1'b0));
  // R3
  hit_poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && (rd_addr_i == last_addr_i)) |=> (rdata_o[7] == !$past(last_data_i[7])));
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_bsr_top.sv
module sim_bsr_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        busy_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic [15:0] last_addr_i = 16'h1234;
  logic [7:0]  last_data_i = 8'h00;
  logic [7:0]  array_data_i = '0;
  logic [7:0]  rdata_o;
  int checks = 0, errors = 0;
  int exp_tog = 0;

  always #2.5 clk_i = ~clk_i;

  bsr_top u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one read: strobe sampled on next posedge, checked at following negedge
  task automatic do_read(input logic [15:0] a, input logic [7:0] arr);
    rd_i = 1'b1; rd_addr_i = a; array_data_i = arr;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  function automatic logic [7:0] exp_stat(input logic [15:0] a);
    return {(a == last_addr_i) ? ~last_data_i[7] : 1'b0, exp_tog[0], 6'b0};
  endfunction

  task automatic busy_read(input logic [15:0] a, input string req);
    logic [7:0] e;
    e = exp_stat(a);
    do_read(a, 8'hA5);
    chk(req, rdata_o, e);
    exp_tog++;
  endtask

  task automatic start_cycle(input logic [7:0] ld);
    last_data_i = ld; busy_i = 1'b1; exp_tog = 0;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1", rdata_o, 8'h00);
  endtask

  task automatic t_idle;
    do_read(16'h0010, 8'h3C); chk("R2", rdata_o, 8'h3C);
    do_read(16'h1234, 8'hC3); chk("R2", rdata_o, 8'hC3);
  endtask

  task automatic t_poll_and_toggle;
    start_cycle(8'h80);
    busy_read(16'h1234, "R3 R5");     // 0x00
    busy_read(16'h0001, "R4 R5 R6");  // 0x40
    busy_read(16'h1234, "R3 R5");     // 0x00
    last_data_i = 8'h7F;
    busy_read(16'h1234, "R3 R6");     // 0xC0
    busy_read(16'hFFFF, "R4 R5");
    // R9 no strobe: output holds
    repeat (3) @(negedge clk_i);
    chk("R9", rdata_o, 8'h00);
    busy_read(16'h0002, "R9 R5");     // toggle unchanged by idle cycles
  endtask

  task automatic t_end_same_edge;
    // R7 read on the edge where busy falls
    busy_i = 1'b0;
    do_read(16'h1234, 8'hD6);
    chk("R7", rdata_o, 8'hD6);
  endtask

  task automatic t_restart_clear;
    // previous cycle left toggle odd; new cycle must start at 0
    start_cycle(8'h00);
    busy_read(16'h0005, "R8");
    busy_i = 1'b0; @(negedge clk_i);
    start_cycle(8'h00);
    busy_read(16'h0005, "R8");
    busy_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic t_rise_same_edge;
    // R10 read strobe on the edge where busy rises
    last_data_i = 8'h00; exp_tog = 0;
    busy_i = 1'b1;
    busy_read(16'h1234, "R10");       // 0x80
    busy_read(16'h1234, "R10");       // 0xC0
    busy_i = 1'b0;
    do_read(16'h0003, 8'h81); chk("R7", rdata_o, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle();
    t_poll_and_toggle();
    t_end_same_edge();
    t_restart_clear();
    t_rise_same_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule